// File: doc/BRIEF.md
# Time-of-Flight Histogramming Time-to-Digital Converter

This block measures photon return times for direct time-of-flight ranging. One start strobe fires the illumination trigger and restarts a coarse time counter that all detector channels share. Each channel synchronizes its detector pulse and detects its rising edge. On the first edge after a start, the channel captures the counter value as its arrival code.

Many shots are fired in a row. Each captured code adds one count to the matching bin of that channel's own histogram, which is held in registers. When the programmed number of shots has been fired, a sequential search scans the bins of every channel in parallel. The index of the fullest bin is reported as the time of flight, together with its count. A clear input empties the histograms, drops the result and loads a new shot target. Each channel can be disabled on its own.

Top module: `tof_hist_tdc`

## Requirements
- R1: A start that arrives while the block is idle is taken at a clock edge. At that edge the counter is set to 0 and laser_trig goes high for exactly the next cycle. Idle means no shot is running, no search is under way and res_valid is low. A start at any other time has no effect: no trigger is issued and the counter is not reset.
- R2: While a shot runs, the counter rises by one on each clock edge and covers codes 0 to 2^CW-1. The shot ends at the edge that follows the cycle in which the counter shows its maximum.
- R3: Each detector input passes through a two-flop synchronizer and a rising-edge detector. A pulse that rises in the cycle after the j-th edge following the start edge yields code j+2. The start edge itself is edge 0.
- R4: Only the first rising edge of a channel in a shot is captured. That channel's last_code field holds the code until the channel captures again in a later shot.
- R5: Each captured code adds one to bin number "code" of that channel's histogram. Channels never affect each other's histograms.
- R6: A pulse whose code would be larger than 2^CW-1, or that arrives after the shot has ended, records nothing. Neither last_code nor the histogram changes.
- R7: A channel whose chan_en bit is 0 neither captures nor counts. Its last_code stays unchanged.
- R8: A histogram bin stops at 2^BW-1 and does not wrap.
- R9: When the shot count reaches the target, every channel's bins are searched from index 0 upward, and then res_valid rises. res_bin gives the index of the largest bin and res_peak gives its count. On a tie the lowest index wins, so an empty histogram reports bin 0 with count 0. The result holds until clear.
- R10: clear empties all bins, resets the shot count, stops any shot or search, drops res_valid and loads shot_target as the new target. After reset the target is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Shot start strobe |
| clear | input | 1 | Empties the histograms and loads shot_target |
| shot_target | input | SCW | Number of shots to accumulate, loaded on clear |
| chan_en | input | NCH | Per-channel enable |
| det_in | input | NCH | Asynchronous detector pulses |
| laser_trig | output | 1 | One-cycle illumination trigger |
| last_code | output | NCH*CW | Latest captured code per channel; channel c is at bits [c*CW +: CW] |
| res_valid | output | 1 | Peak result is available |
| res_bin | output | NCH*CW | Peak bin index per channel |
| res_peak | output | NCH*BW | Peak bin count per channel |

## Verification
Single shots place pulses at known cycle offsets and check the captured codes. These codes expose the synchronizer latency, the counter step and the range limit at the last bin and just beyond it. Other shots add a second pulse in the same shot or a start strobe in the middle of a shot. A correct design then gives the same codes, which separates first-edge capture from re-triggering. Multi-shot runs build histograms with ties, an empty histogram through a disabled channel, and overfull bins. These separate the lowest-index tie rule and saturation from a wrapping or last-wins design. A final clear followed by an empty shot shows that the bins really were emptied.

// File: rtl/tof_hist_tdc.sv
module tof_hist_tdc #(
  parameter int NCH = 2,
  parameter int CW  = 4,
  parameter int BW  = 4,
  parameter int SCW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               clear,
  input  logic [SCW-1:0]     shot_target,
  input  logic [NCH-1:0]     chan_en,
  input  logic [NCH-1:0]     det_in,
  output logic               laser_trig,
  output logic [NCH*CW-1:0]  last_code,
  output logic               res_valid,
  output logic [NCH*CW-1:0]  res_bin,
  output logic [NCH*BW-1:0]  res_peak
);
  localparam int NBIN = 1 << CW;
  localparam logic [CW-1:0]  CMAX  = '1;
  localparam logic [BW-1:0]  HMAX  = '1;
  localparam logic [SCW-1:0] S_ONE = SCW'(1);

  logic [NCH-1:0] s1, s2, s3, done_c, hit;
  logic [CW-1:0]  cnt, idx;
  logic           running, searching;
  logic [SCW-1:0] shots, target;
  logic [BW-1:0]  hist [NCH][NBIN];
  logic [CW-1:0]  lcode [NCH];
  logic [CW-1:0]  best_bin [NCH];
  logic [BW-1:0]  best_cnt [NCH];

  wire idle = !running && !searching && !res_valid;
  wire go   = start && idle;
  assign hit = {NCH{running}} & s2 & ~s3 & chan_en & ~done_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= det_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; idx <= '0; running <= 1'b0; searching <= 1'b0;
      res_valid <= 1'b0; laser_trig <= 1'b0; done_c <= '0;
      shots <= '0; target <= S_ONE;
      for (int c = 0; c < NCH; c++) begin
        lcode[c] <= '0; best_bin[c] <= '0; best_cnt[c] <= '0;
        for (int b = 0; b < NBIN; b++) hist[c][b] <= '0;
      end
    end else if (clear) begin
      running <= 1'b0; searching <= 1'b0; res_valid <= 1'b0;
      laser_trig <= 1'b0; shots <= '0; target <= shot_target;
      for (int c = 0; c < NCH; c++)
        for (int b = 0; b < NBIN; b++) hist[c][b] <= '0;
    end else begin
      laser_trig <= go;
      if (go) begin
        cnt <= '0; running <= 1'b1; done_c <= '0;
      end else if (running) begin
        done_c <= done_c | hit;
        for (int c = 0; c < NCH; c++)
          if (hit[c]) begin
            lcode[c] <= cnt;
            if (hist[c][cnt] != HMAX) hist[c][cnt] <= hist[c][cnt] + 1'b1;
          end
        if (cnt == CMAX) begin
          running <= 1'b0;
          shots   <= shots + S_ONE;
          if (shots + S_ONE == target) begin
            searching <= 1'b1; idx <= '0;
            for (int c = 0; c < NCH; c++) begin
              best_bin[c] <= '0; best_cnt[c] <= '0;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (searching) begin
        for (int c = 0; c < NCH; c++)
          if (hist[c][idx] > best_cnt[c]) begin
            best_cnt[c] <= hist[c][idx]; best_bin[c] <= idx;
          end
        idx <= idx + 1'b1;
        if (idx == CMAX) begin
          searching <= 1'b0; res_valid <= 1'b1;
        end
      end
    end
  end

  // R1
  trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    laser_trig |=> !laser_trig);
  // R1
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && !clear) |=> (laser_trig && cnt == '0 && running));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != CMAX && !clear && !start) |=> (cnt == $past(cnt) + 1'b1));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !clear) |=> res_valid);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign last_code[c*CW +: CW] = lcode[c];
    assign res_bin[c*CW +: CW]   = best_bin[c];
    assign res_peak[c*BW +: BW]  = best_cnt[c];

    // R4
    first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && done_c[c]) |=> $stable(lcode[c]));
    // R7
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |=> $stable(lcode[c]));
    // R9
    bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !clear) |=> $stable(best_bin[c]));
    for (genvar b = 0; b < NBIN; b++) begin : g_bin
      // R8
      no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (hist[c][b] >= $past(hist[c][b])));
    end
  end
endmodule

// File: tb/sim_tof_hist_tdc.sv
`timescale 1ns/1ps
module sim_tof_hist_tdc;
  localparam int NCH = 2, CW = 4, BW = 4, SCW = 8;
  logic clk = 0, rst_n = 0, start = 0, clear = 0;
  logic [SCW-1:0] shot_target = '0;
  logic [NCH-1:0] chan_en = '1, det_in = '0;
  logic laser_trig, res_valid;
  logic [NCH*CW-1:0] last_code, res_bin;
  logic [NCH*BW-1:0] res_peak;
  int checks = 0, failures = 0;
  bit finished = 0;

  tof_hist_tdc #(.NCH(NCH), .CW(CW), .BW(BW), .SCW(SCW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .shot_target(shot_target), .chan_en(chan_en), .det_in(det_in),
    .laser_trig(laser_trig), .last_code(last_code), .res_valid(res_valid),
    .res_bin(res_bin), .res_peak(res_peak));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lc(int c); return int'(last_code[c*CW +: CW]); endfunction
  function automatic int rb(int c); return int'(res_bin[c*CW +: CW]); endfunction
  function automatic int rp(int c); return int'(res_peak[c*BW +: BW]); endfunction

  task automatic do_clear(int t);
    @(negedge clk); clear = 1; shot_target = SCW'(t);
    @(negedge clk); clear = 0;
    chk("R10 clear drops res_valid", int'(res_valid), 0);
  endtask

  // d*: offset of pulse, e*: second pulse on ch0, rs: offset of extra start, tchk: trigger check (1 expect, 0 expect none, -1 skip)
  task automatic shot(int d0, int d1, int e0, int rs, int tchk);
    @(negedge clk); start = 1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      start = (j == rs);
      if (j == 0 && tchk >= 0) chk("R1 trigger after start edge", int'(laser_trig), tchk);
      if (j == 1 && tchk == 1) chk("R1 trigger one cycle", int'(laser_trig), 0);
      det_in[0] = (j == d0 || j == d0 + 1 || j == e0 || j == e0 + 1);
      det_in[1] = (j == d1 || j == d1 + 1);
    end
    det_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_result(string req);
    int n = 0;
    while (!res_valid && n < 80) begin @(negedge clk); n++; end
    chk(req, int'(res_valid), 1);
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", int'(res_valid), 0);
    chk("R1 reset trigger", int'(laser_trig), 0);
  endtask

  task automatic t_codes;
    do_clear(4);
    shot(0, 5, -10, -1, 1);
    chk("R3 ch0 code offset 0", lc(0), 2);
    chk("R5 ch1 code offset 5", lc(1), 7);
    chk("R9 no result before target", int'(res_valid), 0);
    shot(9, 13, -10, -1, -1);
    chk("R3 ch0 code offset 9", lc(0), 11);
    chk("R2 ch1 last code at max", lc(1), 15);
    shot(14, 3, -10, -1, -1);
    chk("R6 ch0 out of range keeps code", lc(0), 11);
    chk("R3 ch1 code offset 3", lc(1), 5);
    shot(2, 3, 8, 6, -1);
    chk("R4 second pulse ignored", lc(0), 4);
    chk("R1 mid-shot start ignored ch1", lc(1), 5);
    wait_result("R9 result after 4 shots");
    chk("R9 ch0 tie lowest bin", rb(0), 2);
    chk("R9 ch0 tie peak", rp(0), 1);
    chk("R9 ch1 peak bin", rb(1), 5);
    chk("R9 ch1 peak count", rp(1), 2);
  endtask

  task automatic t_after_result;
    shot(1, 1, -10, -1, 0);
    chk("R1 start ignored with result", int'(res_valid), 1);
    chk("R9 result held", rb(1), 5);
    chk("R6 no capture after result", lc(0), 4);
  endtask

  task automatic t_disabled;
    do_clear(3);
    chan_en = 2'b01;
    for (int i = 0; i < 3; i++) shot(6, 6, -10, -1, -1);
    wait_result("R7 result with disabled ch");
    chk("R7 disabled keeps code", lc(1), 5);
    chk("R7 disabled empty bin", rb(1), 0);
    chk("R7 disabled empty peak", rp(1), 0);
    chk("R5 enabled bin", rb(0), 8);
    chk("R5 enabled peak", rp(0), 3);
    chan_en = 2'b11;
  endtask

  task automatic t_saturate;
    do_clear(20);
    for (int i = 0; i < 10; i++) shot(1, 1, -10, -1, -1);
    for (int i = 0; i < 10; i++) shot(1, 4, -10, -1, -1);
    wait_result("R8 result after 20 shots");
    chk("R8 saturated bin", rb(0), 3);
    chk("R8 saturated count", rp(0), 15);
    chk("R9 tie 10 vs 10 lowest bin", rb(1), 3);
    chk("R9 tie count", rp(1), 10);
  endtask

  task automatic t_clear_empty;
    do_clear(1);
    shot(-10, -10, -10, -1, 1);
    wait_result("R10 result after 1 shot");
    chk("R10 bins zeroed ch0 bin", rb(0), 0);
    chk("R10 bins zeroed ch0 peak", rp(0), 0);
    chk("R10 bins zeroed ch1 peak", rp(1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_codes;
    t_after_result;
    t_disabled;
    t_saturate;
    t_clear_empty;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule